// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets a host on a two-wire serial bus (I2C-style signalling: START, repeated START, STOP, 8-bit bytes with a ninth acknowledge clock) read and write a 256-location, 8-bit register space. The register space itself lives outside the block. The block presents it through a plain port: a write strobe with address and data, and a read strobe whose data returns one clock later, as a block RAM would return it.

The 7-bit bus address of the slave joins a fixed upper field (zeros by default) with five strap inputs. The straps are captured while reset is held and frozen once reset is released. Both bus lines are oversampled in the system clock domain. An internal byte pointer selects the register. The first data byte of a write transfer sets the pointer, and every byte that is then moved advances it. STOP clears the pointer only when the slave was addressed, while a repeated START keeps it. A pointer-setting write can therefore be chained straight into a read.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) an address byte whose upper 7 bits equal {2'b00, strap_addr}.
- R2: strap_addr is sampled only while rst is high; a change after reset release does not move the bus address until the next reset.
- R3: Bytes travel most significant bit first; bit 0 of the address byte selects read when 1 and write when 0; the slave changes sda_oe only while SCL is low.
- R4: In a write transfer the first data byte loads the pointer; each later byte produces a single-cycle reg_we pulse with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R5: The pointer advances by one after every byte written to or read from a register, wrapping from 0xFF to 0x00.
- R6: A STOP received after a matching address clears the pointer, so a following read returns register 0x00, then 0x01, and so on.
- R7: A START or repeated START leaves the pointer unchanged, so a read after a repeated START returns the register the preceding write pointed at.
- R8: After a non-matching address the slave neither acknowledges nor writes anything, and a STOP seen in that state leaves the pointer unchanged.
- R9: In a read transfer the slave sends the next register after a master ACK; after a master NACK it releases SDA and sends nothing until the next START or STOP.
- R10: After reset the slave does not drive SDA and asserts neither reg_we nor reg_rd.
- R11: The slave acknowledges every byte written to it in a matched write transfer, including the pointer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_addr | input | 5 | Lower five bits of the bus address |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | One-cycle register read strobe; data expected on reg_rdata one clock later |
| reg_rdata | input | 8 | Register read data |

## Verification
A wrong pointer surfaces on the bus only at the next byte that is moved. A faulty STOP or repeated-START rule therefore shows as wrong read data in the first byte of the following read transfer, and a faulty increment or wrap shows in the second byte. A wrong address match or latch shows within the ninth clock of the address byte, as a missing or unwanted acknowledge. A slave left driving after a NACK corrupts the very next bit the master samples. Each scenario is therefore arranged so that the state it targets is read back over the bus one transfer later.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_W,
    ST_AACK_H,
    ST_WR,
    ST_WACK_W,
    ST_WACK_H,
    ST_RD,
    ST_RACK_W,
    ST_RACK_S,
    ST_RLOAD,
    ST_SKIP
  } twi_state_e;

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
  parameter int N_LINES = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] d,
  output logic [N_LINES-1:0] q
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             sda_s,
  output logic             sda_oe,
  output logic [AW-1:0]    reg_addr,
  output logic             reg_we,
  output logic [DW-1:0]    reg_wdata,
  output logic             reg_rd,
  input  logic [DW-1:0]    reg_rdata
);

  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  twi_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sh;
  logic [DW-1:0]    tx;
  logic [DW-1:0]    tx_buf;
  logic [AW-1:0]    ptr;
  logic             rw;
  logic             sel;
  logic             first_wr;
  logic             rd_d;

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '1;
      tx_buf    <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      sel       <= 1'b0;
      first_wr  <= 1'b0;
      rd_d      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_rd <= 1'b0;
      rd_d   <= reg_rd;
      if (rd_d)   tx_buf <= reg_rdata;
      if (reg_we) ptr    <= ptr + 1'b1;

      if (stop_ev) begin
        if (sel) ptr <= '0;
        sel    <= 1'b0;
        sda_oe <= 1'b0;
        state  <= ST_IDLE;
      end else if (start_ev) begin
        cnt    <= '0;
        sda_oe <= 1'b0;
        state  <= ST_ADDR;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (sh[DEV_W-1:0] == dev_addr) begin
                sel      <= 1'b1;
                rw       <= sda_s;
                first_wr <= 1'b1;
                state    <= ST_AACK_W;
              end else begin
                sel   <= 1'b0;
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK_W: if (scl_fall) begin
            sda_oe <= 1'b1;
            if (rw) reg_rd <= 1'b1;
            state  <= ST_AACK_H;
          end
          ST_AACK_H: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= tx_buf;
              sda_oe <= ~tx_buf[DW-1];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_WR: if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (first_wr) begin
                ptr      <= AW'({sh[DW-2:0], sda_s});
                first_wr <= 1'b0;
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= {sh[DW-2:0], sda_s};
              end
              state <= ST_WACK_W;
            end
          end
          ST_WACK_W: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_WACK_H;
          end
          ST_WACK_H: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) state <= ST_RACK_W;
            end else if (scl_fall) begin
              tx     <= {tx[DW-2:0], 1'b1};
              sda_oe <= ~tx[DW-2];
            end
          end
          ST_RACK_W: if (scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_RACK_S;
          end
          ST_RACK_S: if (scl_rise) begin
            if (!sda_s) begin
              reg_rd <= 1'b1;
              state  <= ST_RLOAD;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_RLOAD: if (scl_fall) begin
            tx     <= tx_buf;
            sda_oe <= ~tx_buf[DW-1];
            cnt    <= '0;
            state  <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter int   AW          = 8,
  parameter int   DW          = 8,
  parameter int   DEV_W       = 7,
  parameter int   STRAP_W     = 5,
  parameter int   SYNC_STAGES = 2,
  parameter logic [DEV_W-STRAP_W-1:0] ADDR_HI = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [AW-1:0]      reg_addr,
  output logic               reg_we,
  output logic [DW-1:0]      reg_wdata,
  output logic               reg_rd,
  input  logic [DW-1:0]      reg_rdata
);

  logic [DEV_W-1:0] dev_addr;
  logic [1:0]       lines_s;
  logic             scl_rise, scl_fall, start_ev, stop_ev;

  always_ff @(posedge clk) begin
    if (rst) dev_addr <= {ADDR_HI, strap_addr};
  end

  twi_pin_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );

  twi_bus_events u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_slave_fsm #(.AW(AW), .DW(DW), .DEV_W(DEV_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .dev_addr  (dev_addr),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_s     (lines_s[0]),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          reg_we,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr
);

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  // R4
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_we));

  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_in && $past(scl_in)) |-> $stable(sda_oe));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_in   (scl_in),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr)
);

// File: tb/sim_twi_reg_slave.sv
module sim_twi_reg_slave;

  localparam int CLK_P = 10;
  localparam int Q     = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap = 5'b01111;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_rd;

  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_reg_slave u0 (
    .clk(clk), .rst(rst), .strap_addr(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7) ^ 8'h5A;
  end

  always_ff @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= mem[reg_addr];
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq();
    sda_m = 0; wq();
    scl_m = 0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq();
    scl_m = 1; wq();
    sda_m = 0; wq();
    scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq();
    scl_m = 1; wq();
    sda_m = 1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1; wq(); wq();
      scl_m = 0; wq();
    end
    sda_m = 1; wq();
    scl_m = 1; wq();
    acked = (sda_line == 1'b0);
    wq();
    scl_m = 0; wq();
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1; wq();
      d[i] = sda_line;
      wq();
      scl_m = 0;
    end
    wq();
    sda_m = ack ? 1'b0 : 1'b1; wq();
    scl_m = 1; wq(); wq();
    scl_m = 0; wq();
    sda_m = 1;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
  endtask

  // R10
  task automatic t_reset();
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 reg_we", reg_we, 0);
    chk("R10 reg_rd", reg_rd, 0);
  endtask

  // R1 R11 R4
  task automatic t_write();
    bit a;
    bus_start();
    send_byte({7'h0F, 1'b0}, a); chk("R1 address ack", a, 1);
    send_byte(8'h10, a);         chk("R11 pointer byte ack", a, 1);
    send_byte(8'h11, a);         chk("R11 data ack", a, 1);
    send_byte(8'h22, a);         chk("R11 data ack", a, 1);
    send_byte(8'h33, a);         chk("R11 data ack", a, 1);
    bus_stop();
    exp_m[8'h10] = 8'h11; exp_m[8'h11] = 8'h22; exp_m[8'h12] = 8'h33;
    for (int i = 8'h0F; i <= 8'h13; i++) chk("R4 written register", mem[i], exp_m[i]);
  endtask

  // R6 R3 R9
  task automatic t_read_after_stop();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h0F, 1'b1}, a); chk("R3 read address ack", a, 1);
    read_byte(1, d); chk("R6 first byte is reg 0x00", d, exp_m[0]);
    read_byte(1, d); chk("R6 second byte is reg 0x01", d, exp_m[1]);
    read_byte(0, d); chk("R9 byte before NACK", d, exp_m[2]);
    read_byte(0, d); chk("R9 line released after NACK", d, 8'hFF);
    bus_stop();
  endtask

  // R7 R5
  task automatic t_rep_start();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h0F, 1'b0}, a);
    send_byte(8'h11, a);
    bus_rstart();
    send_byte({7'h0F, 1'b1}, a); chk("R7 read after repeated start ack", a, 1);
    read_byte(1, d); chk("R7 pointer kept", d, exp_m[8'h11]);
    read_byte(0, d); chk("R5 pointer advanced on read", d, exp_m[8'h12]);
    bus_stop();
  endtask

  // R5
  task automatic t_wrap();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h0F, 1'b0}, a);
    send_byte(8'hFE, a);
    send_byte(8'hA1, a);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a);
    exp_m[8'hFE] = 8'hA1; exp_m[8'hFF] = 8'hB2; exp_m[8'h00] = 8'hC3;
    bus_rstart();
    send_byte({7'h0F, 1'b1}, a);
    read_byte(0, d); chk("R5 wrap then read reg 0x01", d, exp_m[1]);
    bus_stop();
    chk("R5 reg 0xFF", mem[8'hFF], exp_m[8'hFF]);
    chk("R5 wrapped write to 0x00", mem[8'h00], exp_m[8'h00]);
  endtask

  // R8
  task automatic t_mismatch();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h0F, 1'b0}, a);
    send_byte(8'h40, a);
    bus_rstart();
    send_byte({7'h0E, 1'b0}, a); chk("R8 no ack on foreign address", a, 0);
    send_byte(8'h99, a);         chk("R8 no ack on foreign data", a, 0);
    bus_stop();
    chk("R8 register untouched", mem[8'h40], exp_m[8'h40]);
    bus_start();
    send_byte({7'h0F, 1'b1}, a);
    read_byte(0, d); chk("R8 stop ignored, pointer still 0x40", d, exp_m[8'h40]);
    bus_stop();
  endtask

  // R2
  task automatic t_strap();
    bit a;
    logic [7:0] d;
    strap = 5'b00011;
    repeat (5) @(negedge clk);
    bus_start();
    send_byte({7'h03, 1'b0}, a); chk("R2 new strap ignored before reset", a, 0);
    bus_stop();
    bus_start();
    send_byte({7'h0F, 1'b1}, a); chk("R2 latched address still answers", a, 1);
    read_byte(0, d);
    bus_stop();
    do_reset();
    bus_start();
    send_byte({7'h03, 1'b1}, a); chk("R2 new address after reset", a, 1);
    read_byte(0, d); chk("R2 pointer 0 after reset", d, exp_m[0]);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_m[i] = 8'(i * 7) ^ 8'h5A;
    do_reset();
    t_reset();
    t_write();
    t_read_after_stop();
    t_rep_start();
    t_wrap();
    t_mismatch();
    t_strap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule